// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A full word address is loaded by either of two strobes: one driven by the processor and one by the memory controller. The upper address bits are then held. The two least significant bits step through a four-word burst each time the advance input is asserted. The order of those steps is chosen per burst. In linear order the offset counts up from the starting offset and wraps around. In interleaved order the offset is the starting offset XORed with the beat number. A new address may be loaded on any cycle, so a caller that never bursts simply loads every cycle and sees its own address.

All inputs are sampled on the rising clock edge. The address output is driven from registers, so a load or advance seen at one edge is visible on `addr_out` right after that edge.

Command decoding has a fixed priority. Either strobe gives **LOAD**. Otherwise, advance gives **ADVANCE**. Otherwise the command is **HOLD**. The beat counter is a four-state machine with states **BEAT0**, **BEAT1**, **BEAT2** and **BEAT3**. It has these transitions:

- **LOAD**, from any state, goes to BEAT0.
- **ADVANCE** goes from BEAT0 to BEAT1, from BEAT1 to BEAT2 and from BEAT2 to BEAT3.
- **ADVANCE** from BEAT3 wraps back to BEAT0.
- **HOLD** keeps the current state.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after its release until the first command, `addr_out` is zero and the beat counter is in BEAT0.
- R2: When either `proc_strobe` or `ctrl_strobe` (or both) is high at a rising edge, `addr_out` equals `addr_in` right after that edge.
- R3: When no strobe is high and `advance` is high at an edge, the beat number increases by one; the upper bits `addr_out[ADDR_W-1:2]` do not change.
- R4: With `order_sel` = 0 (linear) captured at the load, the low two bits equal (start offset + beat) modulo 4, for example start 2 gives 2, 3, 0, 1.
- R5: With `order_sel` = 1 (interleaved) captured at the load, the low two bits equal start offset XOR beat, for example start 1 gives 1, 0, 3, 2. A mode input tied high, the safe value for an unconnected pin, therefore gives interleaved order, and reset leaves the captured order at interleaved.
- R6: `order_sel` is captured only on a load; changing it during a burst has no effect on `addr_out` until the next load.
- R7: A strobe and `advance` high in the same cycle act as a load; the advance is discarded.
- R8: With no strobe and no `advance`, `addr_out` holds its value.
- R9: After four advances the low bits return to the starting offset, and no carry passes into the upper bits, even when they are all ones.
- R10: Loads on consecutive cycles each take effect on the next edge, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | Word address to load |
| proc_strobe | input | 1 | Processor-side load strobe |
| ctrl_strobe | input | 1 | Controller-side load strobe |
| advance | input | 1 | Step to the next beat of the burst |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current word address |

## Verification
Some properties are checked by the assertions on every cycle:

- A load lands in BEAT0 with `addr_out` equal to the loaded address.
- A hold keeps the state.
- An advance from BEAT3 returns to BEAT0.
- The upper address bits move only on a load.
- Both orders agree at beat zero.

Other behaviour is visible only in the bench's scenarios, where a reference model predicts every address:

- The actual linear and interleaved sequences.
- That a mid-burst order change is ignored.
- That there is no carry into the upper bits at the wrap.
- That strobe wins over advance.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_ADV  = 2'd1,
        CMD_LOAD = 2'd2
    } burst_cmd_e;

    typedef enum logic [1:0] {
        BEAT0 = 2'd0,
        BEAT1 = 2'd1,
        BEAT2 = 2'd2,
        BEAT3 = 2'd3
    } beat_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    localparam int unsigned OFS_W = 2;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic       proc_strobe,
    input  logic       ctrl_strobe,
    input  logic       advance,
    output burst_cmd_e cmd
);

    logic any_strobe;

    always_comb begin
        any_strobe = proc_strobe | ctrl_strobe;
        if (any_strobe)
            cmd = CMD_LOAD;
        else if (advance)
            cmd = CMD_ADV;
        else
            cmd = CMD_HOLD;
    end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  burst_cmd_e          cmd,
    output logic [OFS_W-1:0]    beat
);

    beat_state_e state_q;
    beat_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BEAT0;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_LOAD: state_d = BEAT0;
            CMD_ADV: begin
                unique case (state_q)
                    BEAT0: state_d = BEAT1;
                    BEAT1: state_d = BEAT2;
                    BEAT2: state_d = BEAT3;
                    BEAT3: state_d = BEAT0;
                    default: state_d = BEAT0;
                endcase
            end
            default: state_d = state_q;
        endcase
    end

    always_comb begin
        beat = OFS_W'(state_q);
    end

    // R9
    wrap_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BEAT3 && cmd == CMD_ADV) |=> (state_q == BEAT0));

    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_HOLD) |=> $stable(state_q));

    // R2
    load_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (state_q == BEAT0));

endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen
    import burst_seq_pkg::*;
(
    input  logic [OFS_W-1:0] start_ofs,
    input  logic [OFS_W-1:0] beat,
    input  burst_order_e     order,
    output logic [OFS_W-1:0] ofs
);

    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    always_comb begin
        lin_ofs = start_ofs + beat;
        ilv_ofs = start_ofs ^ beat;
        unique case (order)
            ORD_LINEAR:     ofs = lin_ofs;
            ORD_INTERLEAVE: ofs = ilv_ofs;
            default:        ofs = ilv_ofs;
        endcase
    end

    // R4 R5: both orders begin the burst at the starting offset
    always_comb begin
        if (beat == '0)
            beat0_start_chk: assert (lin_ofs == ilv_ofs);
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int unsigned HI_W = ADDR_W - OFS_W;

    burst_cmd_e       cmd;
    logic [OFS_W-1:0] beat;
    logic [OFS_W-1:0] ofs;
    logic [HI_W-1:0]  base_hi_q;
    logic [OFS_W-1:0] start_q;
    burst_order_e     order_q;

    burst_cmd_decode u_dec (
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .advance     (advance),
        .cmd         (cmd)
    );

    burst_beat_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .beat  (beat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi_q <= '0;
            start_q   <= '0;
            order_q   <= ORD_INTERLEAVE;
        end else if (cmd == CMD_LOAD) begin
            base_hi_q <= addr_in[ADDR_W-1:OFS_W];
            start_q   <= addr_in[OFS_W-1:0];
            order_q   <= burst_order_e'(order_sel);
        end
    end

    burst_offset_gen u_ofs (
        .start_ofs (start_q),
        .beat      (beat),
        .order     (order_q),
        .ofs       (ofs)
    );

    always_comb begin
        addr_out = {base_hi_q, ofs};
    end

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe || ctrl_strobe) |=> (addr_out == $past(addr_in)));

    // R3 R9
    upper_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(proc_strobe || ctrl_strobe) |=> $stable(addr_out[ADDR_W-1:OFS_W]));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(proc_strobe || ctrl_strobe || advance) |=> $stable(addr_out));

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int unsigned AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          proc_strobe = 1'b0;
    logic          ctrl_strobe = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat = '0;
    logic          m_ord = 1'b1;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_in     (addr_in),
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .advance     (advance),
        .order_sel   (order_sel),
        .addr_out    (addr_out)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = m_ord ? (m_start ^ m_beat) : (m_start + m_beat);
        return {m_hi, lo};
    endfunction

    task automatic step(input logic ps, input logic cs, input logic adv,
                        input logic ord, input logic [AW-1:0] a, input string tag);
        proc_strobe = ps;
        ctrl_strobe = cs;
        advance     = adv;
        order_sel   = ord;
        addr_in     = a;
        @(posedge clk);
        if (ps || cs) begin
            m_hi    = a[AW-1:2];
            m_start = a[1:0];
            m_beat  = 2'd0;
            m_ord   = ord;
        end else if (adv) begin
            m_beat = m_beat + 2'd1;
        end
        exp_q.push_back(model_addr());
        tag_q.push_back(tag);
        #1;
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [AW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (addr_out !== e) begin
                fails++;
                $display("FAIL %s: addr_out=%h expected=%h", t, addr_out, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (addr_out !== '0) begin
            fails++;
            $display("FAIL R1: addr_out=%h expected=%h", addr_out, {AW{1'b0}});
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(0, 0, 0, 0, '0, "R1 after release");
        step(0, 0, 1, 0, '0, "R3 advance from reset");

        // R4: linear from start 2, then R9 wrap
        step(1, 0, 0, 0, 17'h0A5A, "R2 proc load linear");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, '0, "R4/R9 linear beat");
        step(0, 0, 1, 0, '0, "R3 linear beat after wrap");

        // R5: interleaved from start 1 via controller strobe
        step(0, 1, 0, 1, 17'h1F3D, "R2 ctrl load interleaved");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, '0, "R5/R9 interleaved beat");

        // R8: holds
        step(0, 0, 1, 1, '0, "R3 step before hold");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, '0, "R8 hold");

        // R6: order flips mid-burst
        step(1, 1, 0, 0, 17'h0003, "R2 both strobes load");
        step(0, 0, 1, 1, '0, "R6 order change ignored");
        step(0, 0, 1, 1, '0, "R6 order change ignored");

        // R7: strobe beats advance
        step(1, 0, 1, 1, 17'h12346, "R7 strobe over advance");
        step(0, 1, 1, 0, 17'h00011, "R7 strobe over advance");

        // R9: no carry into all-ones upper bits
        step(1, 0, 0, 0, 17'h1FFFF, "R9 top address load");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, '0, "R9 no carry");
        step(0, 1, 0, 1, 17'h1FFFE, "R9 top address interleaved");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 1, '0, "R9 no carry interleaved");

        // R10: back-to-back loads
        for (int i = 0; i < 6; i++)
            step(i[0], ~i[0], 0, i[1], 17'(i * 4099 + 7), "R10 consecutive load");

        // mixed traffic
        for (int i = 0; i < 200; i++) begin
            logic [2:0] r;
            r = 3'($urandom);
            step(r == 3'd0, r == 3'd1, r[2], 1'($urandom), 17'($urandom), "R3/R7/R8 mixed");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule